// File: doc/BRIEF.md
# Nonvolatile Byte Array Programming Controller

This block sits on a CPU's special-function register bus and gives software access to a 256-byte nonvolatile array. It has five byte-wide registers: two address bytes, a data byte, an operation-length byte and a command byte. Software places an address and, for programming, a data value. It then writes the command byte with its go bit set. The command byte also holds a two-bit operation code, which selects a read, a byte program, an erase of one 32-byte row, or an erase of the whole array.

Reads take effect at once. Program and erase operations are timed. A prescaler divides the system clock by a fixed ratio. A down-counter, loaded from the length register, counts prescaled ticks, and this count is repeated a fixed number of times, so the busy time grows linearly with the length value. Software picks the length value to suit its oscillator. While an operation runs, the block rejects register writes and reports busy. When the operation ends, it commits the change to the array and raises a one-cycle completion pulse that serves as an interrupt request. The array model behaves like program-only cells: a program can only clear bits, and only an erase sets them back to FFh.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset the length register reads 08h, the address, data and command registers read 00h, busy and the completion pulse are 0, and every array byte holds FFh.
- R2: The registers answer at bus addresses F2h (address low), F3h (address high), F4h (data), F5h (length) and F6h (command), and each one reads back what was written to it while idle. Any other address reads 00h.
- R3: Writing the command register with bit 7 set and op code 00 (read) loads the data register with the byte at the low address at that clock edge. It starts no timed cycle, so busy stays 0 and no completion pulse is issued.
- R4: Op code 01 (byte program) replaces the addressed byte with the bitwise AND of its old value and the data register.
- R5: Op code 10 (row erase) sets to FFh all 32 bytes whose address bits 7:5 match those of the low address. Other bytes keep their values, and the data register has no effect.
- R6: Op code 11 (block erase) sets all 256 bytes to FFh.
- R7: A program or erase holds busy high for exactly PRESC_DIV × L × REPEATS clock cycles after the accepting edge. L is the length register value, and a value of 0 counts as 1. The defaults are PRESC_DIV 4 and REPEATS 2.
- R8: The array change and the fall of busy happen at the same clock edge. The completion output is high for exactly that one following cycle.
- R9: While busy, writes to the address, data, length and command registers are ignored. The command register reads with bit 7 = 1 and bits 1:0 = the running op code.
- R10: Only the low address byte selects the array byte. The high address byte is stored and read back but does not change which byte an operation touches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data (combinational from sfr_addr) |
| busy | output | 1 | A timed program or erase is running |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
Several properties are checked on every cycle. The completion pulse lasts one cycle, and it always coincides with the fall of busy. The address and length registers hold their values when a write arrives during busy. A read command never raises busy. The array never receives two strobes at once, and the operation counter never starts while it is already running.

Some behaviour only the bench scenarios can show: the exact busy length for several length values, including zero; the AND-only result of programming over data already present; the limits of a row erase; and the fact that the high address byte does not redirect operations. The bench observes each of these through register reads after the operation ends.

// File: rtl/nvm_prog_pkg.sv
// Package: shared constants and types for the nonvolatile array controller.
// Assumes an 8-bit register bus and a byte-wide array.
package nvm_prog_pkg;

    localparam int BYTE_W = 8;

    // Register bus addresses
    localparam logic [7:0] SFR_ADR_LO = 8'hF2;
    localparam logic [7:0] SFR_ADR_HI = 8'hF3;
    localparam logic [7:0] SFR_DATA   = 8'hF4;
    localparam logic [7:0] SFR_LEN    = 8'hF5;
    localparam logic [7:0] SFR_CMD    = 8'hF6;

    // Command register layout
    localparam int CMD_GO_BIT = 7;

    typedef enum logic [1:0] {
        OP_READ      = 2'b00,
        OP_PROG      = 2'b01,
        OP_ROW_ERASE = 2'b10,
        OP_BLK_ERASE = 2'b11
    } nvm_op_e;

endpackage

// File: rtl/nvm_op_timer.sv
// Module: operation-length timer.
// A prescaler divides clk by PRESC_DIV. A down-counter loaded with the
// length value counts prescaled ticks, and the whole count is repeated
// REPEATS times. A length of 0 is treated as 1. 'running' is high for
// PRESC_DIV*L*REPEATS cycles after the start edge, and 'expire' marks the
// last of them. Assumes start is only raised while idle.
module nvm_op_timer #(
    parameter int PRESC_DIV = 4,
    parameter int REPEATS   = 2,
    parameter int LEN_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len_val,
    output logic             running,
    output logic             expire
);

    localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
    localparam int RW = (REPEATS > 1) ? $clog2(REPEATS) : 1;
    localparam logic [PW-1:0] PRE_MAX = PW'(PRESC_DIV - 1);
    localparam logic [RW-1:0] REP_MAX = RW'(REPEATS - 1);

    logic [PW-1:0]    pre_q;
    logic [LEN_W-1:0] tick_q;
    logic [LEN_W-1:0] reload_q;
    logic [RW-1:0]    rep_q;
    logic [LEN_W-1:0] len_eff;
    logic             pre_end, tick_end, rep_end;

    // Treat a zero length as the shortest legal count.
    assign len_eff  = (len_val == '0) ? LEN_W'(1) : len_val;
    assign pre_end  = (pre_q == '0);
    assign tick_end = (tick_q == LEN_W'(1));
    assign rep_end  = (rep_q == '0);
    assign expire   = running && pre_end && tick_end && rep_end;

    // Prescaler, tick counter and repeat counter, nested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            pre_q    <= '0;
            tick_q   <= '0;
            reload_q <= '0;
            rep_q    <= '0;
        end else if (start && !running) begin
            running  <= 1'b1;
            pre_q    <= PRE_MAX;
            tick_q   <= len_eff;
            reload_q <= len_eff;
            rep_q    <= REP_MAX;
        end else if (running) begin
            if (!pre_end) begin
                pre_q <= pre_q - 1'b1;
            end else begin
                pre_q <= PRE_MAX;
                if (!tick_end) begin
                    tick_q <= tick_q - 1'b1;
                end else begin
                    tick_q <= reload_q;
                    if (!rep_end) rep_q <= rep_q - 1'b1;
                    else          running <= 1'b0;
                end
            end
        end
    end

    AST_TICK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (tick_q != '0)); // R7
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !running); // R9
    AST_STOP_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !running); // R8

endmodule

// File: rtl/nvm_byte_array.sv
// Module: behavioural model of a program-only byte array.
// Holds 2**ADDR_W bytes, all FFh after reset. A program strobe ANDs the
// write data into the addressed byte. A row erase sets to FFh every byte
// whose upper address bits (above ROW_ADDR_BITS) match. A block erase sets
// every byte to FFh. The read port is combinational. Assumes at most one
// strobe per cycle.
module nvm_byte_array #(
    parameter int ADDR_W        = 8,
    parameter int ROW_ADDR_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              prog_stb,
    input  logic              row_erase_stb,
    input  logic              blk_erase_stb,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0]        mem_q [DEPTH];
    logic [ADDR_W-1:0] row_sel;

    assign row_sel = addr >> ROW_ADDR_BITS;
    assign rdata   = mem_q[addr];

    // Apply erase or program to each cell selected by the current strobe.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem_q[i] <= 8'hFF;
            end else if (blk_erase_stb ||
                         (row_erase_stb && ((ADDR_W'(i) >> ROW_ADDR_BITS) == row_sel))) begin
                mem_q[i] <= 8'hFF;
            end else if (prog_stb && (ADDR_W'(i) == addr)) begin
                mem_q[i] <= mem_q[i] & wdata;
            end
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_stb, row_erase_stb, blk_erase_stb})); // R4

endmodule

// File: rtl/nvm_prog_ctrl.sv
// Module: top of the nonvolatile array programming controller.
// Holds the five bus registers, decodes commands, launches the timer for
// program and erase operations, and commits to the array when the timer
// expires. Register writes are refused while busy. Assumes a single-cycle
// write strobe and a combinational read path.
module nvm_prog_ctrl #(
    parameter int         ADDR_W        = 8,
    parameter int         ROW_ADDR_BITS = 5,
    parameter int         PRESC_DIV     = 4,
    parameter int         REPEATS       = 2,
    parameter logic [7:0] LEN_RESET     = 8'h08
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sfr_addr,
    input  logic       sfr_wr,
    input  logic [7:0] sfr_wdata,
    output logic [7:0] sfr_rdata,
    output logic       busy,
    output logic       done_irq
);
    import nvm_prog_pkg::*;

    logic [7:0] adr_lo_q, adr_hi_q, dat_q, len_q;
    nvm_op_e    op_q, op_new;
    logic       done_q;
    logic       wr_lo, wr_hi, wr_dat, wr_len, wr_cmd;
    logic       go_req, rd_launch, tm_launch;
    logic       tmr_run, tmr_exp;
    logic [7:0] arr_rdata;

    // Decode the bus writes that are accepted (idle only).
    assign wr_lo  = sfr_wr && !busy && (sfr_addr == SFR_ADR_LO);
    assign wr_hi  = sfr_wr && !busy && (sfr_addr == SFR_ADR_HI);
    assign wr_dat = sfr_wr && !busy && (sfr_addr == SFR_DATA);
    assign wr_len = sfr_wr && !busy && (sfr_addr == SFR_LEN);
    assign wr_cmd = sfr_wr && !busy && (sfr_addr == SFR_CMD);

    // Classify a go command as an immediate read or a timed operation.
    assign op_new    = nvm_op_e'(sfr_wdata[1:0]);
    assign go_req    = wr_cmd && sfr_wdata[CMD_GO_BIT];
    assign rd_launch = go_req && (op_new == OP_READ);
    assign tm_launch = go_req && (op_new != OP_READ);

    assign busy     = tmr_run;
    assign done_irq = done_q;

    // Address, length and command registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_lo_q <= '0;
            adr_hi_q <= '0;
            len_q    <= LEN_RESET;
            op_q     <= OP_READ;
        end else begin
            if (wr_lo)  adr_lo_q <= sfr_wdata;
            if (wr_hi)  adr_hi_q <= sfr_wdata;
            if (wr_len) len_q    <= sfr_wdata;
            if (wr_cmd) op_q     <= op_new;
        end
    end

    // Data register: written by the bus or loaded by a read command.
    always_ff @(posedge clk) begin
        if (!rst_n)         dat_q <= '0;
        else if (wr_dat)    dat_q <= sfr_wdata;
        else if (rd_launch) dat_q <= arr_rdata;
    end

    // Completion pulse at the edge where the timer expires.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= tmr_exp;
    end

    // Combinational read-back of the registers.
    always_comb begin
        case (sfr_addr)
            SFR_ADR_LO: sfr_rdata = adr_lo_q;
            SFR_ADR_HI: sfr_rdata = adr_hi_q;
            SFR_DATA:   sfr_rdata = dat_q;
            SFR_LEN:    sfr_rdata = len_q;
            SFR_CMD:    sfr_rdata = {busy, 5'b0, op_q};
            default:    sfr_rdata = 8'h00;
        endcase
    end

    nvm_op_timer #(
        .PRESC_DIV (PRESC_DIV),
        .REPEATS   (REPEATS),
        .LEN_W     (8)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tm_launch),
        .len_val (len_q),
        .running (tmr_run),
        .expire  (tmr_exp)
    );

    nvm_byte_array #(
        .ADDR_W        (ADDR_W),
        .ROW_ADDR_BITS (ROW_ADDR_BITS)
    ) i_array (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr          (adr_lo_q[ADDR_W-1:0]),
        .wdata         (dat_q),
        .prog_stb      (tmr_exp && (op_q == OP_PROG)),
        .row_erase_stb (tmr_exp && (op_q == OP_ROW_ERASE)),
        .blk_erase_stb (tmr_exp && (op_q == OP_BLK_ERASE)),
        .rdata         (arr_rdata)
    );

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R8
    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_q); // R8
    AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sfr_wr && (sfr_addr == SFR_ADR_LO)) |=> (adr_lo_q == $past(adr_lo_q))); // R9
    AST_LEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sfr_wr && (sfr_addr == SFR_LEN)) |=> (len_q == $past(len_q))); // R9
    AST_READ_UNTIMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sfr_wr && (sfr_addr == SFR_CMD) && sfr_wdata[CMD_GO_BIT] &&
         (sfr_wdata[1:0] == 2'b00)) |=> !busy); // R3

endmodule

// File: tb/test_nvm_prog_ctrl.sv
// Directed bench: one task per scenario. Inputs are driven and outputs
// sampled on the falling edge.
module test_nvm_prog_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic       busy, done_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    nvm_prog_ctrl i_nvm_prog_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_addr  (sfr_addr),
        .sfr_wr    (sfr_wr),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata),
        .busy      (busy),
        .done_irq  (done_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    task automatic read_cell(input logic [7:0] a, output logic [7:0] d);
        bus_wr(8'hF2, a);
        bus_wr(8'hF6, 8'h80);
        bus_rd(8'hF4, d);
    endtask

    // Start a timed op and measure busy length and the done pulse.
    task automatic run_timed(input logic [1:0] op, input int exp_cyc, input string req);
        int cnt = 0;
        bus_wr(8'hF6, {6'b100000, op});
        while (busy === 1'b1 && cnt < 100000) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == exp_cyc, {req, " busy length"}, cnt, exp_cyc);
        chk(done_irq === 1'b1, "R8 done at busy fall", done_irq, 1);
        @(negedge clk);
        chk(done_irq === 1'b0, "R8 done one cycle", done_irq, 0);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_rd(8'hF5, v); chk(v == 8'h08, "R1 length reset", v, 8'h08);
        bus_rd(8'hF2, v); chk(v == 8'h00, "R1 addr lo reset", v, 0);
        bus_rd(8'hF3, v); chk(v == 8'h00, "R1 addr hi reset", v, 0);
        bus_rd(8'hF4, v); chk(v == 8'h00, "R1 data reset", v, 0);
        bus_rd(8'hF6, v); chk(v == 8'h00, "R1 cmd reset", v, 0);
        chk(busy === 1'b0 && done_irq === 1'b0, "R1 busy/done reset", {busy, done_irq}, 0);
        read_cell(8'h00, v);
        chk(v == 8'hFF, "R1 array erased", v, 8'hFF);
        chk(busy === 1'b0 && done_irq === 1'b0, "R3 read untimed", {busy, done_irq}, 0);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        bus_wr(8'hF2, 8'h5A); bus_rd(8'hF2, v); chk(v == 8'h5A, "R2 addr lo", v, 8'h5A);
        bus_wr(8'hF3, 8'hA5); bus_rd(8'hF3, v); chk(v == 8'hA5, "R2 addr hi", v, 8'hA5);
        bus_wr(8'hF4, 8'h3C); bus_rd(8'hF4, v); chk(v == 8'h3C, "R2 data", v, 8'h3C);
        bus_wr(8'hF5, 8'h03); bus_rd(8'hF5, v); chk(v == 8'h03, "R2 length", v, 8'h03);
        bus_wr(8'hF6, 8'h02); bus_rd(8'hF6, v); chk(v == 8'h02, "R2 cmd op no go", v, 8'h02);
        chk(busy === 1'b0, "R2 no go no busy", busy, 0);
        bus_rd(8'h80, v); chk(v == 8'h00, "R2 unmapped", v, 0);
        bus_wr(8'hF3, 8'h00);
    endtask

    task automatic t_program();
        logic [7:0] v;
        bus_wr(8'hF2, 8'h25); bus_wr(8'hF4, 8'hF0);
        run_timed(2'b01, 24, "R7 L=3");
        read_cell(8'h25, v); chk(v == 8'hF0, "R4 program erased cell", v, 8'hF0);
        bus_wr(8'hF4, 8'h3C);
        run_timed(2'b01, 24, "R7 L=3 again");
        read_cell(8'h25, v); chk(v == 8'h30, "R4 program ANDs", v, 8'h30);
    endtask

    task automatic t_busy_lock();
        logic [7:0] v;
        int w = 0;
        bus_wr(8'hF2, 8'h26); bus_wr(8'hF4, 8'h0F);
        bus_wr(8'hF6, 8'h81);
        bus_wr(8'hF2, 8'h99); bus_wr(8'hF4, 8'h00);
        bus_wr(8'hF5, 8'h77); bus_wr(8'hF6, 8'h83);
        bus_rd(8'hF6, v); chk(v == 8'h81, "R9 cmd reads busy", v, 8'h81);
        bus_rd(8'hF2, v); chk(v == 8'h26, "R9 addr locked", v, 8'h26);
        bus_rd(8'hF5, v); chk(v == 8'h03, "R9 length locked", v, 8'h03);
        bus_rd(8'hF4, v); chk(v == 8'h0F, "R9 data locked", v, 8'h0F);
        while (busy === 1'b1 && w < 100000) begin w++; @(negedge clk); end
        chk(done_irq === 1'b1, "R8 done after locked run", done_irq, 1);
        bus_rd(8'hF6, v); chk(v == 8'h01, "R9 op unchanged", v, 8'h01);
        read_cell(8'h26, v); chk(v == 8'h0F, "R9 programmed with locked data", v, 8'h0F);
    endtask

    task automatic t_row_erase();
        logic [7:0] v;
        bus_wr(8'hF2, 8'h40); bus_wr(8'hF4, 8'h11); run_timed(2'b01, 24, "R7 prog row2");
        bus_wr(8'hF2, 8'h1F); bus_wr(8'hF4, 8'h22); run_timed(2'b01, 24, "R7 prog row0");
        bus_wr(8'hF2, 8'h3F); bus_wr(8'hF4, 8'h00);
        run_timed(2'b10, 24, "R7 row erase");
        read_cell(8'h25, v); chk(v == 8'hFF, "R5 row byte 25 erased", v, 8'hFF);
        read_cell(8'h26, v); chk(v == 8'hFF, "R5 row byte 26 erased", v, 8'hFF);
        read_cell(8'h40, v); chk(v == 8'h11, "R5 next row kept", v, 8'h11);
        read_cell(8'h1F, v); chk(v == 8'h22, "R5 prior row kept", v, 8'h22);
    endtask

    task automatic t_zero_len();
        logic [7:0] v;
        bus_wr(8'hF5, 8'h00);
        bus_wr(8'hF2, 8'h01); bus_wr(8'hF4, 8'hA5);
        run_timed(2'b01, 8, "R7 L=0 as 1");
        read_cell(8'h01, v); chk(v == 8'hA5, "R7 zero-length program", v, 8'hA5);
    endtask

    task automatic t_addr_hi();
        logic [7:0] v;
        bus_wr(8'hF3, 8'h01);
        read_cell(8'h40, v); chk(v == 8'h11, "R10 hi byte no redirect", v, 8'h11);
        bus_rd(8'hF3, v); chk(v == 8'h01, "R10 hi byte stored", v, 8'h01);
    endtask

    task automatic t_block_erase();
        logic [7:0] v;
        bus_wr(8'hF5, 8'h02);
        bus_wr(8'hF4, 8'h00);
        run_timed(2'b11, 16, "R7 L=2 block");
        read_cell(8'h40, v); chk(v == 8'hFF, "R6 byte 40", v, 8'hFF);
        read_cell(8'h1F, v); chk(v == 8'hFF, "R6 byte 1F", v, 8'hFF);
        read_cell(8'h01, v); chk(v == 8'hFF, "R6 byte 01", v, 8'hFF);
        read_cell(8'hFF, v); chk(v == 8'hFF, "R6 byte FF", v, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_program();
        t_busy_lock();
        t_row_erase();
        t_zero_len();
        t_addr_hi();
        t_block_erase();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule